// File: doc/BRIEF.md
# Pixel Channel Multiplexer Sequencer

This block steers one shared converter across three colour sample paths (red, green, blue). For every pixel, a pixel-sample strobe restarts a short channel sequence. Each rising edge of the converter clock then moves the selection to the next channel of that sequence. The length and order of the sequence come from a few configuration bits:
- a three-channel enable;
- an order bit;
- three per-channel enable bits that are used when the three-channel enable is clear.

Both the strobe and the converter clock arrive without a fixed phase to the system clock. Each one passes through a synchroniser of `SYNC_STAGES` flops, and its rising edges are detected in the system clock domain. When a strobe rising edge is detected, the next system clock edge sets the selection to the first channel of the configured order and raises a one-cycle pixel-start marker. The selection is offered both as a one-hot vector and as a 2-bit code. The configuration inputs are decoded combinationally against the current position in the sequence.

Top module: `pix_chan_seq`

## Requirements
- R1: A detected rising edge of the pixel strobe sets the selection to the first channel of the configured order, and `pix_start` is high for exactly one system clock cycle per strobe rising edge.
- R2: Each detected rising edge of the converter clock moves the selection to the next channel of the configured sequence.
- R3: Once the last channel of the sequence is selected, further converter clock edges leave the selection unchanged until the next strobe edge.
- R4: With `tri_mode`=1 and `order_fwd`=1 the sequence is red, green, blue. With `tri_mode`=1 and `order_fwd`=0 the sequence is blue, green, red.
- R5: With `tri_mode`=1 the enable bits `en_red`, `en_grn` and `en_blu` have no effect on the selection.
- R6: With `tri_mode`=0 and exactly two enable bits set, the sequence has two entries. With `order_fwd`=1 they are taken in red-green-blue priority (red then green, red then blue, or green then blue). With `order_fwd`=0 that order is reversed.
- R7: With `tri_mode`=0 and exactly one enable bit set, the selection stays on that channel whatever converter clock edges arrive.
- R8: With `tri_mode`=0 and either no enable bit or all three enable bits set, the selection is red only.
- R9: `sel_code` encodes red as 0, green as 1 and blue as 2. `sel_onehot` bit 0 is red, bit 1 is green and bit 2 is blue. Exactly one bit of `sel_onehot` is set at all times, and it agrees with `sel_code`.
- R10: When a strobe rising edge and a converter clock rising edge are detected in the same cycle, the strobe wins and the selection goes to the first channel.
- R11: While `rst` is high, and after it is released with no edges seen, the sequence position is the first slot and `pix_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_strobe_in | input | 1 | Asynchronous pixel-sample strobe; its rising edge restarts the sequence |
| conv_clk_in | input | 1 | Asynchronous converter clock; its rising edge advances the sequence |
| tri_mode | input | 1 | 1 selects three-channel operation |
| order_fwd | input | 1 | 1 selects red-first order, 0 selects blue-first order |
| en_red | input | 1 | Red enable for reduced-channel operation |
| en_grn | input | 1 | Green enable for reduced-channel operation |
| en_blu | input | 1 | Blue enable for reduced-channel operation |
| sel_onehot | output | 3 | One-hot channel select (bit 0 red, bit 1 green, bit 2 blue) |
| sel_code | output | 2 | Encoded channel select (0 red, 1 green, 2 blue) |
| pix_start | output | 1 | One-cycle marker at the start of each pixel |

## Verification
The sequence position is held in a register and decoded combinationally, so a wrong position appears on `sel_code` and `sel_onehot` in the cycle after the edge that produced it. A missed restart leaves the selection on the last channel of the previous pixel instead of the first channel. A position that runs past the end of the sequence shows up as a channel outside the configured set, or as a channel that changes after the hold point. Each stimulus vector applies one strobe and then a counted number of converter clock pulses, so the channel seen at the end identifies exactly how many advances the block took.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    // en[2] red, en[1] green, en[0] blue
    typedef struct packed {
        logic       tri_mode;
        logic       order_fwd;
        logic [2:0] en;
    } seq_cfg_t;

    localparam int MAX_SLOTS = 3;
    localparam int SLOT_W    = $clog2(MAX_SLOTS);

    function automatic logic [SLOT_W-1:0] seq_len(input seq_cfg_t c);
        if (c.tri_mode)
            return SLOT_W'(3);
        else if ($countones(c.en) == 2)
            return SLOT_W'(2);
        else
            return SLOT_W'(1);
    endfunction

    function automatic chan_e seq_chan(input seq_cfg_t c, input logic [SLOT_W-1:0] slot);
        chan_e first;
        chan_e second;
        if (c.tri_mode) begin
            case (slot)
                SLOT_W'(0): return c.order_fwd ? CH_RED : CH_BLU;
                SLOT_W'(1): return CH_GRN;
                default:    return c.order_fwd ? CH_BLU : CH_RED;
            endcase
        end else if ($countones(c.en) == 2) begin
            first  = c.en[2] ? CH_RED : CH_GRN;
            second = c.en[0] ? CH_BLU : CH_GRN;
            if (slot == SLOT_W'(0))
                return c.order_fwd ? first : second;
            else
                return c.order_fwd ? second : first;
        end else if ($countones(c.en) == 1) begin
            return c.en[2] ? CH_RED : (c.en[1] ? CH_GRN : CH_BLU);
        end else begin
            return CH_RED;
        end
    endfunction

    function automatic logic [2:0] chan_onehot(input chan_e ch);
        case (ch)
            CH_RED:  return 3'b001;
            CH_GRN:  return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

endpackage

// File: rtl/pcs_sync_edge.sv
module pcs_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= async_in;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[SYNC_STAGES-1];
    end

    assign rise = chain[SYNC_STAGES-1] & ~prev;

    p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pcs_slot_ctr.sv
module pcs_slot_ctr
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_rise,
    input  logic              conv_rise,
    input  logic [SLOT_W-1:0] len,
    output logic [SLOT_W-1:0] slot,
    output logic              pix_start
);
    logic more;
    assign more = ({1'b0, slot} + (SLOT_W+1)'(1)) < {1'b0, len};

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= '0;
            pix_start <= 1'b0;
        end else begin
            pix_start <= pix_rise;
            if (pix_rise)
                slot <= '0;
            else if (conv_rise && more)
                slot <= slot + SLOT_W'(1);
        end
    end

    p_restart_r1: assert property (@(posedge clk) disable iff (rst)
        pix_rise |=> (slot == '0) && pix_start);

    p_priority_r10: assert property (@(posedge clk) disable iff (rst)
        (pix_rise && conv_rise) |=> (slot == '0));

    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (conv_rise && !pix_rise && more) |=> (slot == $past(slot) + SLOT_W'(1)));

    p_hold_last_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_rise && !pix_rise && !more) |=> $stable(slot));

    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!pix_rise && !conv_rise) |=> ($stable(slot) && !pix_start));

endmodule

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_cfg_t          cfg,
    input  logic [SLOT_W-1:0] slot,
    output logic [2:0]        sel_onehot,
    output logic [1:0]        sel_code
);
    chan_e ch;

    always_comb begin
        ch         = seq_chan(cfg, slot);
        sel_code   = ch;
        sel_onehot = chan_onehot(ch);
    end

    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot(sel_onehot) && sel_code != 2'd3);

    p_single_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg.tri_mode && $countones(cfg.en) == 1 && $stable(cfg))
            |=> ($stable(cfg) -> $stable(sel_code)));

endmodule

// File: rtl/pix_chan_seq.sv
module pix_chan_seq
    import pcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pix_strobe_in,
    input  logic       conv_clk_in,
    input  logic       tri_mode,
    input  logic       order_fwd,
    input  logic       en_red,
    input  logic       en_grn,
    input  logic       en_blu,
    output logic [2:0] sel_onehot,
    output logic [1:0] sel_code,
    output logic       pix_start
);
    logic              pix_rise;
    logic              conv_rise;
    logic [SLOT_W-1:0] slot;
    seq_cfg_t          cfg;

    assign cfg = '{tri_mode: tri_mode, order_fwd: order_fwd, en: {en_red, en_grn, en_blu}};

    pcs_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pix_sync (
        .clk(clk), .rst(rst), .async_in(pix_strobe_in), .rise(pix_rise));

    pcs_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_conv_sync (
        .clk(clk), .rst(rst), .async_in(conv_clk_in), .rise(conv_rise));

    pcs_slot_ctr u_ctr (
        .clk(clk), .rst(rst), .pix_rise(pix_rise), .conv_rise(conv_rise),
        .len(seq_len(cfg)), .slot(slot), .pix_start(pix_start));

    pcs_decode u_dec (
        .clk(clk), .rst(rst), .cfg(cfg), .slot(slot),
        .sel_onehot(sel_onehot), .sel_code(sel_code));

    p_tri_ignores_en_r5: assert property (@(posedge clk) disable iff (rst)
        (tri_mode && $stable(tri_mode) && $stable(order_fwd) && $stable(slot))
            |-> $stable(sel_code));

endmodule

// File: tb/sim_pix_chan_seq.sv
module sim_pix_chan_seq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 22;

    // {tri, fwd, en_r, en_g, en_b, n_conv[2:0], exp_code[1:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b1,1'b1,3'b000,3'd0,2'd0},  // R4 fwd start red
        {1'b1,1'b1,3'b000,3'd1,2'd1},  // R2 -> green
        {1'b1,1'b1,3'b000,3'd2,2'd2},  // R2 -> blue
        {1'b1,1'b1,3'b000,3'd5,2'd2},  // R3 hold blue
        {1'b1,1'b0,3'b000,3'd0,2'd2},  // R4 rev start blue
        {1'b1,1'b0,3'b000,3'd1,2'd1},  // R4 rev green
        {1'b1,1'b0,3'b000,3'd3,2'd0},  // R3 rev hold red
        {1'b1,1'b1,3'b010,3'd0,2'd0},  // R5 enables ignored
        {1'b1,1'b0,3'b001,3'd2,2'd0},  // R5 enables ignored
        {1'b0,1'b1,3'b110,3'd0,2'd0},  // R6 RG first red
        {1'b0,1'b1,3'b110,3'd1,2'd1},  // R6 RG second green
        {1'b0,1'b1,3'b110,3'd3,2'd1},  // R3 two-ch hold
        {1'b0,1'b0,3'b110,3'd0,2'd1},  // R6 GR first green
        {1'b0,1'b0,3'b110,3'd1,2'd0},  // R6 GR second red
        {1'b0,1'b1,3'b011,3'd1,2'd2},  // R6 GB second blue
        {1'b0,1'b0,3'b101,3'd0,2'd2},  // R6 BR first blue
        {1'b0,1'b0,3'b101,3'd2,2'd0},  // R6 BR hold red
        {1'b0,1'b1,3'b001,3'd5,2'd2},  // R7 single blue
        {1'b0,1'b0,3'b010,3'd3,2'd1},  // R7 single green
        {1'b0,1'b1,3'b100,3'd2,2'd0},  // R7 single red
        {1'b0,1'b1,3'b000,3'd2,2'd0},  // R8 none -> red
        {1'b0,1'b0,3'b111,3'd1,2'd0}   // R8 all -> red
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_strobe_in = 1'b0;
    logic       conv_clk_in = 1'b0;
    logic       tri_mode = 1'b1;
    logic       order_fwd = 1'b1;
    logic       en_red = 1'b0;
    logic       en_grn = 1'b0;
    logic       en_blu = 1'b0;
    logic [2:0] sel_onehot;
    logic [1:0] sel_code;
    logic       pix_start;

    int checks = 0;
    int fails = 0;
    int starts = 0;

    pix_chan_seq u0 (
        .clk(clk), .rst(rst), .pix_strobe_in(pix_strobe_in), .conv_clk_in(conv_clk_in),
        .tri_mode(tri_mode), .order_fwd(order_fwd), .en_red(en_red), .en_grn(en_grn),
        .en_blu(en_blu), .sel_onehot(sel_onehot), .sel_code(sel_code), .pix_start(pix_start));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (!rst && pix_start) starts++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        pix_strobe_in = 1'b1;
        repeat (4) @(negedge clk);
        pix_strobe_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic conv(input int n);
        for (int i = 0; i < n; i++) begin
            conv_clk_in = 1'b1;
            repeat (4) @(negedge clk);
            conv_clk_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    function automatic logic [2:0] oh(input logic [1:0] c);
        return 3'b001 << c;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        // R11 reset state
        check("R11 pix_start in reset", pix_start, 0);
        check("R11 code in reset", sel_code, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 code after reset", sel_code, 0);
        check("R11 pix_start after reset", pix_start, 0);
        check("R9 onehot after reset", sel_onehot, 3'b001);

        for (int v = 0; v < NVEC; v++) begin
            logic [9:0] e;
            e = VEC[v];
            {tri_mode, order_fwd, en_red, en_grn, en_blu} = e[9:5];
            s0 = starts;
            strobe();
            check("R1 one start per strobe", starts - s0, 1);
            conv(int'(e[4:2]));
            check($sformatf("R2 vector %0d code", v), sel_code, e[1:0]);
            check($sformatf("R9 vector %0d onehot", v), sel_onehot, oh(e[1:0]));
        end

        // R1 restart after a finished sequence
        tri_mode = 1'b1; order_fwd = 1'b1;
        strobe(); conv(2);
        check("R3 at last before restart", sel_code, 2);
        strobe();
        check("R1 restart to first", sel_code, 0);

        // R10 strobe and converter edge together
        conv(1);
        check("R2 advanced before collision", sel_code, 1);
        pix_strobe_in = 1'b1; conv_clk_in = 1'b1;
        repeat (4) @(negedge clk);
        pix_strobe_in = 1'b0; conv_clk_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 strobe wins", sel_code, 0);

        // R5 enables toggled mid-pixel in three-channel mode
        conv(1);
        en_red = 1'b1; en_blu = 1'b1;
        @(negedge clk);
        check("R5 enable change no effect", sel_code, 1);
        en_red = 1'b0; en_blu = 1'b0;

        // R11 reset mid-sequence returns to first slot
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 reset clears slot", sel_code, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule